// File: doc/BRIEF.md
# Indexed RTC Register File

This block holds the byte-wide register space of a real-time clock, reached through one pair of bus addresses. Writing the even address selects one of 128 byte locations. Reading or writing the odd address then touches the selected byte. Each location has its own meaning:

- Seven time bytes.
- Three alarm bytes.
- Four control bytes: rate/oscillator, mode, flags and status.
- General storage above those.

Some control bits are read-only. Some are forced when written. The flag byte clears itself when it is read.

Two neighbours talk to the block. A calendar counter sends update-start and update-end pulses and presents the current time. On update-end the block copies that time into its time bytes, checks the alarm and raises the update-ended flag. When software writes a time byte, the block hands the bytes back to the calendar with a one-cycle load pulse. A periodic divider sends tick pulses and reads the rate and enable bits.

All flag events end on a single level interrupt line. The line stays high until software reads the flag byte.

Top module: `rtcx_regfile`

## Requirements
- R1: A write to the even bus address (bus_addr_i = 0) stores wdata[6:0] as the byte index. A read of the even address returns 0xFF.
- R2: After reset, index 10 (rate byte) reads 0x26, index 11 (mode byte) reads 0x02, index 12 (flag byte) reads 0x00, index 13 (status byte) reads 0x80, and the interrupt is low.
- R3: Bit 7 of index 10 is the update-in-progress bit. A host write to index 10 keeps that bit and takes bits 6:0 from the data. An update-start pulse sets the bit while mode bit 7 (SET) is clear. An update-end pulse clears it.
- R4: A write to index 11 with data bit 7 set clears the update-in-progress bit and stores the data with bit 4 forced to 0. So a stored SET bit is never seen together with bit 4.
- R5: Writes to indices 12 and 13 leave both bytes unchanged.
- R6: A read of index 12 returns the current flags. On that clock edge the byte becomes 0x00 and the interrupt drops. A flag event in the same cycle as the read is still recorded, and the interrupt is raised again.
- R7: On update-end with mode bit 5 set, 0xA0 is ORed into index 12 when each alarm byte (index 1 against seconds, index 3 against minutes, index 5 against hours) either has bits 7:6 = 11 or equals the current-time byte from the calendar.
- R8: On update-end with mode bit 4 set, 0x90 is ORed into index 12.
- R9: A host write to a time byte (index 0, 2, 4, 6, 7, 8 or 9) while SET is clear pulses tm_load_o for one cycle, one clock after the write. A write to index 11 that clears a set SET bit also pulses it. tm_o always shows the stored time bytes, seconds in bits 7:0, then indices 2, 4, 6, 7, 8, 9 upward.
- R10: Any flag event raises irq_o. It stays high, across further events, until index 12 is read. irq_o always equals bit 7 of index 12.
- R11: Indices 1, 3, 5 and 14 to 127 are plain read/write bytes.
- R12: Update-end copies cal_now_i into the time bytes only when SET is clear. A host write to a time byte in the same cycle takes precedence over the copy.
- R13: A periodic tick ORs 0xC0 into index 12 only when mode bit 6 is set and bits 3:0 of index 10 are nonzero. per_rate_o, per_en_o, div_sel_o and fmt_o mirror index 10 bits 3:0, index 11 bit 6, index 10 bits 6:4 and index 11 bits 2:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access strobe, one access per cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = index port, 1 = data port |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current access |
| upd_start_i | input | 1 | Calendar update-start pulse |
| upd_end_i | input | 1 | Calendar update-end pulse |
| per_tick_i | input | 1 | Periodic divider event pulse |
| cal_now_i | input | 56 | Current time bytes from the calendar |
| tm_o | output | 56 | Stored time bytes toward the calendar |
| tm_load_o | output | 1 | Load strobe for tm_o |
| irq_o | output | 1 | Level interrupt |
| per_rate_o | output | 4 | Periodic rate select |
| per_en_o | output | 1 | Periodic event enable |
| div_sel_o | output | 3 | Oscillator divider select |
| fmt_o | output | 2 | Data-mode and 24-hour bits |

## Verification
Corrupted control state reaches the ports within one clock. The mode bits are mirrored on per_en_o and fmt_o, and the rate bits on per_rate_o and div_sel_o, every cycle. A stuck or lost flag in index 12 shows on irq_o in the cycle after the event or the read. A lost update-in-progress bit, a missed forced bit 4, or a time copy taken under SET only appears when software reads the byte back, so every such case is followed by a readback. Same-cycle read and event collisions are driven on purpose, because the ordering inside the next-state logic is where a wrong choice would hide.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;

    localparam int DW     = 8;
    localparam int IW     = 7;
    localparam int NTIME  = 7;
    localparam int NALM   = 3;
    localparam int NBYTES = 1 << IW;

    localparam logic [IW-1:0] IX_RATE = 7'd10;
    localparam logic [IW-1:0] IX_MODE = 7'd11;
    localparam logic [IW-1:0] IX_FLAG = 7'd12;
    localparam logic [IW-1:0] IX_STAT = 7'd13;
    localparam int            RAM_BASE  = 14;
    localparam int            RAM_DEPTH = NBYTES - RAM_BASE;

    localparam logic [DW-1:0] RST_RATE = 8'h26;
    localparam logic [DW-1:0] RST_MODE = 8'h02;
    localparam logic [DW-1:0] RST_STAT = 8'h80;

    localparam logic [DW-1:0] EV_PER = 8'hC0;
    localparam logic [DW-1:0] EV_ALM = 8'hA0;
    localparam logic [DW-1:0] EV_UPD = 8'h90;

    localparam int M_SET = 7;
    localparam int M_PIE = 6;
    localparam int M_AIE = 5;
    localparam int M_UIE = 4;
    localparam int R_UIP = 7;

    typedef struct packed {
        logic [IW-1:0]             idx;
        logic [DW-1:0]             rate;
        logic [DW-1:0]             mode;
        logic [DW-1:0]             flag;
        logic                      irq;
        logic                      tload;
        logic [NTIME-1:0][DW-1:0]  tm;
        logic [NALM-1:0][DW-1:0]   alm;
    } regs_t;

    function automatic logic is_time(input logic [IW-1:0] i);
        return (i == 7'd0) || (i == 7'd2) || (i == 7'd4) || ((i >= 7'd6) && (i <= 7'd9));
    endfunction

    function automatic logic [2:0] time_slot(input logic [IW-1:0] i);
        return (i < 7'd6) ? {1'b0, i[2:1]} : 3'(i - 7'd3);
    endfunction

    function automatic logic is_alarm(input logic [IW-1:0] i);
        return (i == 7'd1) || (i == 7'd3) || (i == 7'd5);
    endfunction

endpackage

// File: rtl/rtcx_store.sv
module rtcx_store #(
    parameter int DW    = 8,
    parameter int AW    = 7,
    parameter int BASE  = 14,
    parameter int DEPTH = 114
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wloc;
    logic [AW-1:0] rloc;

    assign wloc = waddr_i - AW'(BASE);
    assign rloc = raddr_i - AW'(BASE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (we_i && (32'(wloc) < DEPTH)) begin
            mem_q[wloc] <= wdata_i;
        end
    end

    assign rdata_o = (32'(rloc) < DEPTH) ? mem_q[rloc] : '0;
endmodule

// File: rtl/rtcx_alarm_cmp.sv
module rtcx_alarm_cmp #(
    parameter int NALM = 3,
    parameter int DW   = 8
) (
    input  logic [NALM-1:0][DW-1:0] alm_i,
    input  logic [NALM-1:0][DW-1:0] now_i,
    output logic                    match_o
);
    logic [NALM-1:0] hit;

    for (genvar g = 0; g < NALM; g++) begin : g_byte
        assign hit[g] = (alm_i[g][DW-1:DW-2] == 2'b11) || (alm_i[g] == now_i[g]);
    end

    assign match_o = &hit;
endmodule

// File: rtl/rtcx_regfile.sv
module rtcx_regfile
    import rtcx_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic                bus_addr_i,
    input  logic [DW-1:0]       bus_wdata_i,
    output logic [DW-1:0]       bus_rdata_o,
    input  logic                upd_start_i,
    input  logic                upd_end_i,
    input  logic                per_tick_i,
    input  logic [NTIME*DW-1:0] cal_now_i,
    output logic [NTIME*DW-1:0] tm_o,
    output logic                tm_load_o,
    output logic                irq_o,
    output logic [3:0]          per_rate_o,
    output logic                per_en_o,
    output logic [2:0]          div_sel_o,
    output logic [1:0]          fmt_o
);
    regs_t st_d, st_q;

    logic [NTIME-1:0][DW-1:0] cal_w;
    logic [DW-1:0]            ev;
    logic                     alm_hit;
    logic                     host_wr;
    logic                     host_rd;
    logic                     ram_we;
    logic [DW-1:0]            ram_rdata;

    // observation copies for the bound checker
    logic [IW-1:0] idx_w;
    logic [DW-1:0] rate_w, mode_w, flag_w;

    assign cal_w   = cal_now_i;
    assign host_wr = bus_sel_i & bus_wr_i & bus_addr_i;
    assign host_rd = bus_sel_i & ~bus_wr_i & bus_addr_i;
    assign ram_we  = host_wr && (32'(st_q.idx) >= RAM_BASE);

    rtcx_alarm_cmp #(.NALM(NALM), .DW(DW)) i_alarm (
        .alm_i   (st_q.alm),
        .now_i   (cal_w[NALM-1:0]),
        .match_o (alm_hit)
    );

    rtcx_store #(.DW(DW), .AW(IW), .BASE(RAM_BASE), .DEPTH(RAM_DEPTH)) i_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (ram_we),
        .waddr_i (st_q.idx),
        .wdata_i (bus_wdata_i),
        .raddr_i (st_q.idx),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.tload = 1'b0;
        ev         = '0;

        // calendar and divider events act on the stored state first
        if (upd_end_i) begin
            if (!st_q.mode[M_SET]) st_d.tm = cal_w;
            if (st_q.mode[M_AIE] && alm_hit) ev = ev | EV_ALM;
            if (st_q.mode[M_UIE]) ev = ev | EV_UPD;
            st_d.rate[R_UIP] = 1'b0;
        end
        if (upd_start_i && !st_q.mode[M_SET]) st_d.rate[R_UIP] = 1'b1;
        if (per_tick_i && st_q.mode[M_PIE] && (st_q.rate[3:0] != 4'd0)) ev = ev | EV_PER;

        // host access is applied on top
        if (bus_sel_i && bus_wr_i && !bus_addr_i) st_d.idx = bus_wdata_i[IW-1:0];

        if (host_wr) begin
            if (is_time(st_q.idx)) begin
                st_d.tm[time_slot(st_q.idx)] = bus_wdata_i;
                if (!st_q.mode[M_SET]) st_d.tload = 1'b1;
            end else if (is_alarm(st_q.idx)) begin
                st_d.alm[st_q.idx[2:1]] = bus_wdata_i;
            end else if (st_q.idx == IX_RATE) begin
                st_d.rate = {st_d.rate[R_UIP], bus_wdata_i[R_UIP-1:0]};
            end else if (st_q.idx == IX_MODE) begin
                if (bus_wdata_i[M_SET]) begin
                    st_d.rate[R_UIP] = 1'b0;
                    st_d.mode        = bus_wdata_i & ~(8'd1 << M_UIE);
                end else begin
                    if (st_q.mode[M_SET]) st_d.tload = 1'b1;
                    st_d.mode = bus_wdata_i;
                end
            end
        end

        if (host_rd && (st_q.idx == IX_FLAG)) begin
            st_d.flag = '0;
            st_d.irq  = 1'b0;
        end

        st_d.flag = st_d.flag | ev;
        if (ev != '0) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.rate <= RST_RATE;
            st_q.mode <= RST_MODE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!bus_addr_i)                 bus_rdata_o = 8'hFF;
        else if (is_time(st_q.idx))      bus_rdata_o = st_q.tm[time_slot(st_q.idx)];
        else if (is_alarm(st_q.idx))     bus_rdata_o = st_q.alm[st_q.idx[2:1]];
        else if (st_q.idx == IX_RATE)    bus_rdata_o = st_q.rate;
        else if (st_q.idx == IX_MODE)    bus_rdata_o = st_q.mode;
        else if (st_q.idx == IX_FLAG)    bus_rdata_o = st_q.flag;
        else if (st_q.idx == IX_STAT)    bus_rdata_o = RST_STAT;
        else                             bus_rdata_o = ram_rdata;
    end

    assign tm_o       = st_q.tm;
    assign tm_load_o  = st_q.tload;
    assign irq_o      = st_q.irq;
    assign per_rate_o = st_q.rate[3:0];
    assign per_en_o   = st_q.mode[M_PIE];
    assign div_sel_o  = st_q.rate[6:4];
    assign fmt_o      = st_q.mode[2:1];

    assign idx_w  = st_q.idx;
    assign rate_w = st_q.rate;
    assign mode_w = st_q.mode;
    assign flag_w = st_q.flag;
endmodule

// File: rtl/rtcx_chk.sv
module rtcx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       wr,
    input logic       addr,
    input logic [7:0] wdata,
    input logic       ustart,
    input logic       uend,
    input logic       ptick,
    input logic [6:0] idx,
    input logic [7:0] rate,
    input logic [7:0] mode,
    input logic [7:0] flag,
    input logic       irq,
    input logic       tload
);
    logic flag_rd;
    logic time_ix;
    assign flag_rd = sel && !wr && addr && (idx == 7'd12);
    assign time_ix = (idx == 7'd0) || (idx == 7'd2) || (idx == 7'd4) || ((idx >= 7'd6) && (idx <= 7'd9));

    AST_UIP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr && idx == 7'd10 && !ustart && !uend) |=> rate[7] == $past(rate[7])); // R3

    AST_SET_NO_UIE: assert property (@(posedge clk) disable iff (!rst_n)
        mode[7] |-> !mode[4]); // R4

    AST_SET_CLEARS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr && idx == 7'd11 && wdata[7] && !ustart) |=> (!rate[7] && mode[7])); // R4

    AST_FLAG_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr && idx == 7'd12 && !uend && !ptick) |=> flag == $past(flag)); // R5

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !uend && !ptick) |=> (flag == 8'h00 && !irq)); // R6

    AST_UPD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (uend && mode[4]) |=> (flag[7] && flag[4] && irq)); // R8

    AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr && time_ix && !mode[7]) |=> tload); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_rd) |=> irq); // R10

    AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq == flag[7]); // R10
endmodule

bind rtcx_regfile rtcx_chk i_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .sel    (bus_sel_i),
    .wr     (bus_wr_i),
    .addr   (bus_addr_i),
    .wdata  (bus_wdata_i),
    .ustart (upd_start_i),
    .uend   (upd_end_i),
    .ptick  (per_tick_i),
    .idx    (idx_w),
    .rate   (rate_w),
    .mode   (mode_w),
    .flag   (flag_w),
    .irq    (irq_o),
    .tload  (tm_load_o)
);

// File: tb/test_rtcx_regfile.sv
module test_rtcx_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [7:0]  wdata = '0;
    logic        us = 1'b0, ue = 1'b0, pt = 1'b0;
    logic [55:0] cal = '0;

    logic [7:0]  rdata;
    logic [55:0] tm;
    logic        tload, irq, pen;
    logic [3:0]  prate;
    logic [2:0]  dsel;
    logic [1:0]  fmt;

    always #4 clk = ~clk;

    rtcx_regfile i_rtcx_regfile (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .upd_start_i(us), .upd_end_i(ue), .per_tick_i(pt),
        .cal_now_i(cal), .tm_o(tm), .tm_load_o(tload), .irq_o(irq),
        .per_rate_o(prate), .per_en_o(pen), .div_sel_o(dsel), .fmt_o(fmt)
    );

    int nchk = 0;
    int nerr = 0;

    // behavioural reference state
    logic [7:0] mm [128];
    logic [6:0] midx;
    logic       mirq;
    logic       mtl;

    function automatic int tix(input int j);
        return (j < 3) ? 2 * j : j + 3;
    endfunction

    function automatic bit time_index(input int i);
        return i == 0 || i == 2 || i == 4 || (i >= 6 && i <= 9);
    endfunction

    task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 128; k++) mm[k] = 8'h00;
        mm[10] = 8'h26; mm[11] = 8'h02; mm[13] = 8'h80;
        midx = '0; mirq = 1'b0; mtl = 1'b0;
    endtask

    task automatic model_step();
        logic [7:0] ev;
        logic [7:0] a;
        bit hit;
        ev  = 8'h00;
        mtl = 1'b0;
        if (ue) begin
            if (!mm[11][7]) for (int j = 0; j < 7; j++) mm[tix(j)] = cal[j*8 +: 8];
            hit = 1'b1;
            for (int j = 0; j < 3; j++) begin
                a = mm[2*j+1];
                if (!(a[7:6] == 2'b11 || a == cal[j*8 +: 8])) hit = 1'b0;
            end
            if (mm[11][5] && hit) ev = ev | 8'hA0;
            if (mm[11][4]) ev = ev | 8'h90;
            mm[10][7] = 1'b0;
        end
        if (us && !mm[11][7]) mm[10][7] = 1'b1;
        if (pt && mm[11][6] && mm[10][3:0] != 4'd0) ev = ev | 8'hC0;
        if (sel) begin
            if (!addr) begin
                if (wr) midx = wdata[6:0];
            end else if (wr) begin
                case (int'(midx))
                    10: mm[10] = {mm[10][7], wdata[6:0]};
                    11: begin
                        if (wdata[7]) begin
                            mm[10][7] = 1'b0;
                            mm[11] = wdata & 8'hEF;
                        end else begin
                            if (mm[11][7]) mtl = 1'b1;
                            mm[11] = wdata;
                        end
                    end
                    12, 13: ;
                    default: begin
                        mm[midx] = wdata;
                        if (time_index(int'(midx)) && !mm[11][7]) mtl = 1'b1;
                    end
                endcase
            end else if (midx == 7'd12) begin
                mm[12] = 8'h00;
                mirq = 1'b0;
            end
        end
        mm[12] = mm[12] | ev;
        if (ev != 8'h00) mirq = 1'b1;
    endtask

    task automatic compare_outputs();
        logic [55:0] etm;
        for (int j = 0; j < 7; j++) etm[j*8 +: 8] = mm[tix(j)];
        chk("R10", "irq", 64'(irq), 64'(mirq));
        chk("R9", "tm_load", 64'(tload), 64'(mtl));
        chk("R12", "tm", 64'(tm), 64'(etm));
        chk("R13", "ctl", 64'({prate, pen, dsel, fmt}),
            64'({mm[10][3:0], mm[11][6], mm[10][6:4], mm[11][2:1]}));
    endtask

    // one clock: check read data before the edge, step the model, compare after
    task automatic tick(input string r);
        #1;
        if (sel && !wr) chk(r, "rdata", 64'(rdata), 64'(addr ? mm[midx] : 8'hFF));
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_outputs();
        sel = 1'b0; wr = 1'b0; addr = 1'b0; wdata = '0;
        us = 1'b0; ue = 1'b0; pt = 1'b0;
    endtask

    task automatic set_idx(input logic [7:0] i);
        sel = 1'b1; wr = 1'b1; addr = 1'b0; wdata = i; tick("R1");
    endtask

    task automatic wreg(input logic [7:0] i, input logic [7:0] v);
        set_idx(i);
        sel = 1'b1; wr = 1'b1; addr = 1'b1; wdata = v; tick("R11");
    endtask

    task automatic rreg(input logic [7:0] i, input string r);
        set_idx(i);
        sel = 1'b1; wr = 1'b0; addr = 1'b1; tick(r);
    endtask

    task automatic event_tick(input logic s, input logic e, input logic p, input string r);
        us = s; ue = e; pt = p; tick(r);
    endtask

    initial begin
        #(8 * 100000);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_outputs();

        // R2 reset values
        rreg(8'd10, "R2"); rreg(8'd11, "R2"); rreg(8'd12, "R2"); rreg(8'd13, "R2");
        // R1 even read
        sel = 1'b1; wr = 1'b0; addr = 1'b0; tick("R1");
        // R1 index takes only bits 6:0
        wreg(8'h8E, 8'h3C); rreg(8'd14, "R1");

        // R11 storage and alarm bytes
        wreg(8'd14, 8'h5A); wreg(8'd127, 8'hA5); wreg(8'd3, 8'h33);
        rreg(8'd14, "R11"); rreg(8'd127, "R11"); rreg(8'd3, "R11");
        for (int k = 20; k < 28; k++) wreg(8'(k), 8'(k * 7));
        for (int k = 20; k < 28; k++) rreg(8'(k), "R11");

        // R3 update-in-progress handling
        wreg(8'd10, 8'hFF); rreg(8'd10, "R3");
        event_tick(1'b1, 1'b0, 1'b0, "R3"); rreg(8'd10, "R3");
        wreg(8'd10, 8'h26); rreg(8'd10, "R3");
        cal = 56'h09_12_25_03_08_15_30;
        event_tick(1'b0, 1'b1, 1'b0, "R12");
        rreg(8'd10, "R3"); rreg(8'd0, "R12"); rreg(8'd9, "R12");

        // R5 read-only bytes
        wreg(8'd12, 8'hFF); wreg(8'd13, 8'h00);
        rreg(8'd12, "R5"); rreg(8'd13, "R5");

        // R8 update-ended flag, R10 sticky interrupt, R13 periodic
        wreg(8'd11, 8'h12);
        event_tick(1'b0, 1'b1, 1'b0, "R8");
        repeat (3) tick("R10");
        wreg(8'd11, 8'h52);
        event_tick(1'b0, 1'b0, 1'b1, "R13");
        rreg(8'd12, "R6"); rreg(8'd12, "R6");

        // R6 read colliding with a periodic event
        set_idx(8'd12);
        sel = 1'b1; wr = 1'b0; addr = 1'b1; pt = 1'b1; tick("R6");
        rreg(8'd12, "R6");

        // R13 zero rate suppresses the periodic flag
        wreg(8'd10, 8'h20);
        event_tick(1'b0, 1'b0, 1'b1, "R13");
        rreg(8'd12, "R13");
        wreg(8'd10, 8'h26);

        // R7 alarm compare
        wreg(8'd11, 8'h22);
        wreg(8'd1, 8'hC0); wreg(8'd3, 8'hC0); wreg(8'd5, 8'hC0);
        event_tick(1'b0, 1'b1, 1'b0, "R7"); rreg(8'd12, "R7");
        wreg(8'd1, 8'h30); wreg(8'd3, 8'h15); wreg(8'd5, 8'h08);
        cal = 56'h09_12_25_03_08_15_30;
        event_tick(1'b0, 1'b1, 1'b0, "R7"); rreg(8'd12, "R7");
        cal = 56'h09_12_25_03_08_15_31;
        event_tick(1'b0, 1'b1, 1'b0, "R7"); rreg(8'd12, "R7");
        wreg(8'd1, 8'hC1);
        event_tick(1'b0, 1'b1, 1'b0, "R7"); rreg(8'd12, "R7");

        // R4 SET write, R12 no copy under SET, R9 load pulses
        event_tick(1'b1, 1'b0, 1'b0, "R3");
        wreg(8'd11, 8'h92);
        rreg(8'd11, "R4"); rreg(8'd10, "R4");
        event_tick(1'b1, 1'b0, 1'b0, "R3"); rreg(8'd10, "R3");
        wreg(8'd0, 8'h45);
        cal = 56'h10_01_01_02_00_00_00;
        event_tick(1'b0, 1'b1, 1'b0, "R12"); rreg(8'd0, "R12");
        wreg(8'd11, 8'h02);
        wreg(8'd2, 8'h59);
        rreg(8'd2, "R9");

        // R12 host write in the same cycle as the copy
        set_idx(8'd4);
        sel = 1'b1; wr = 1'b1; addr = 1'b1; wdata = 8'h11; ue = 1'b1; tick("R12");
        rreg(8'd4, "R12"); rreg(8'd6, "R12");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
        $finish;
    end
endmodule